// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block guards the pin configuration fields of one I/O port. It watches accesses to a single lock register. Software first writes a pin mask. It then proves intent with a fixed three-write key pattern on one key bit, followed by a read. Once the key is accepted, the masked pins have their configuration write enables held off until the next reset.

The bus decoder delivers write and read strobes that are already qualified for the lock register, together with the access size and the write data. The block returns the register read value, the 16-bit mask, the key status and one inhibit vector per configuration field. Those fields are the 2-bit mode, the output-type bit, the 2-bit drive speed, the 2-bit pull selection and the 4-bit function select. The configuration storage sits elsewhere and combines each inhibit with its own write enable.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset the mask, the key status, every inhibit output and the read value are all zero.
- R2: While the key is inactive, writes update the mask from data bits [15:0]. Access size is encoded 00 byte, 01 halfword, 10 word, 11 reserved. A byte write updates only mask bits [7:0]. A halfword or word write updates all 16 mask bits. A reserved-size write leaves the mask unchanged.
- R3: Three word writes whose key bit (data bit 16) is 1, then 0, then 1, all carrying the same mask in [15:0], followed by a read, activate the key. The key status is 1 from the cycle after that read.
- R4: The read that completes the pattern returns key bit 1. Before that read the key status output stays 0.
- R5: A mask value that differs from the one given at the first key write aborts the pattern. After the abort, a read does not activate the key.
- R6: A byte, halfword or reserved-size write anywhere in the pattern aborts it.
- R7: A read before the pattern is complete aborts it. So does a write with key bit 0 at any step other than the second.
- R8: A word write with key bit 1 at any step that does not complete the pattern restarts it as a new first step. That step carries its own mask.
- R9: Once the key is active, it stays 1 and the mask stays frozen: later writes and key patterns change neither. Only reset clears them.
- R10: Pin i's inhibits are asserted exactly when the key is active and mask bit i is 1. These are mode bits [2i+1:2i], output-type bit i, speed bits [2i+1:2i], pull bits [2i+1:2i] and select bits [4i+3:4i].
- R11: The read value holds the mask in bits [15:0] and the key in bit 16. Bits [31:17] always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the lock register |
| rd_en | input | 1 | Read strobe for the lock register |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| wdata | input | 32 | Write data; [15:0] mask, [16] key |
| rdata | output | 32 | Lock register read value |
| lock_mask | output | 16 | Current pin mask |
| key_active | output | 1 | Key accepted; lock in force |
| inh_mode | output | 32 | Mode field write inhibit, 2 bits per pin |
| inh_otype | output | 16 | Output-type write inhibit, 1 bit per pin |
| inh_speed | output | 32 | Speed field write inhibit, 2 bits per pin |
| inh_pull | output | 32 | Pull field write inhibit, 2 bits per pin |
| inh_afsel | output | 64 | Function select write inhibit, 4 bits per pin |

## Verification
The correct pattern is swept over every single-pin mask and several dense masks. Each pass checks that all five inhibit vectors match the mask pin by pin, so a mis-wired lane or field width shows up. Each broken pattern is tried on its own: a mask change at the second and at the third step, a narrow access at each step, an early read, and a wrong key order. In every case the bench reads back afterwards to confirm the key stayed inactive, which separates an aborted pattern from one that still commits. Restart patterns show that a repeated key-1 write opens a new pattern instead of being rejected. Writes after locking show that the freeze holds until reset.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_GOT1   = 3'd1,
    ST_GOT0   = 3'd2,
    ST_ARMED  = 3'd3,
    ST_LOCKED = 3'd4
  } seq_state_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  function automatic logic is_word(input logic [1:0] sz);
    return sz == SZ_WORD;
  endfunction

  function automatic logic covers_upper(input logic [1:0] sz);
    return (sz == SZ_WORD) || (sz == SZ_HALF);
  endfunction

  function automatic logic covers_lower(input logic [1:0] sz);
    return (sz == SZ_WORD) || (sz == SZ_HALF) || (sz == SZ_BYTE);
  endfunction

endpackage

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import cfg_lock_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      acc_size,
  input  logic            wkey,
  input  logic [PINS-1:0] wmask,
  output seq_state_t      state,
  output logic            locked,
  output logic            key_rd,
  output logic            commit_ev,
  output logic            abort_ev
);

  seq_state_t      st_q, st_d;
  logic [PINS-1:0] ref_q, ref_d;
  logic            mask_same;

  assign mask_same = (wmask == ref_q);

  always_comb begin
    st_d  = st_q;
    ref_d = ref_q;
    if (st_q != ST_LOCKED) begin
      if (wr_en) begin
        if (!is_word(acc_size)) begin
          st_d = ST_IDLE;
        end else if (wkey) begin
          if (st_q == ST_GOT0 && mask_same) begin
            st_d = ST_ARMED;
          end else begin
            st_d  = ST_GOT1;
            ref_d = wmask;
          end
        end else begin
          if (st_q == ST_GOT1 && mask_same) st_d = ST_GOT0;
          else                              st_d = ST_IDLE;
        end
      end else if (rd_en) begin
        st_d = (st_q == ST_ARMED) ? ST_LOCKED : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ref_q <= '0;
    end else begin
      st_q  <= st_d;
      ref_q <= ref_d;
    end
  end

  assign state     = st_q;
  assign locked    = (st_q == ST_LOCKED);
  assign key_rd    = locked || (st_q == ST_ARMED);
  assign commit_ev = (st_q == ST_ARMED) && rd_en && !wr_en;
  assign abort_ev  = (st_q != ST_IDLE) && (st_q != ST_LOCKED) && (st_d == ST_IDLE);

  p_key_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_lock_needs_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(st_q == ST_ARMED && rd_en && !wr_en));

  p_armed_after_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && $past(st_q) != ST_ARMED) |-> $past(st_q) == ST_GOT0);

  p_narrow_aborts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_en && !is_word(acc_size)) |=> st_q == ST_IDLE);

  p_restart_on_key1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_en && is_word(acc_size) && wkey && st_q != ST_GOT0)
      |=> st_q == ST_GOT1);

endmodule

// File: rtl/cfg_lock_mask.sv
module cfg_lock_mask
  import cfg_lock_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      acc_size,
  input  logic [PINS-1:0] wmask,
  input  logic            locked,
  output logic [PINS-1:0] mask
);

  localparam int LOW_LANE = (PINS < 8) ? PINS : 8;

  function automatic logic [PINS-1:0] lane_enable(input logic [1:0] sz);
    logic [PINS-1:0] en;
    for (int i = 0; i < PINS; i++) begin
      en[i] = (i < LOW_LANE) ? covers_lower(sz) : covers_upper(sz);
    end
    return en;
  endfunction

  logic [PINS-1:0] mask_q;
  logic [PINS-1:0] bit_we;

  assign bit_we = (wr_en && !locked) ? lane_enable(acc_size) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= (mask_q & ~bit_we) | (wmask & bit_we);
    end
  end

  assign mask = mask_q;

  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mask_q));

  p_no_write_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/cfg_lock_fanout.sv
module cfg_lock_fanout #(
  parameter int PINS   = 16,
  parameter int MODE_W = 2,
  parameter int SPD_W  = 2,
  parameter int PULL_W = 2,
  parameter int AFS_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PINS-1:0]        mask,
  input  logic                   locked,
  output logic [PINS*MODE_W-1:0] inh_mode,
  output logic [PINS-1:0]        inh_otype,
  output logic [PINS*SPD_W-1:0]  inh_speed,
  output logic [PINS*PULL_W-1:0] inh_pull,
  output logic [PINS*AFS_W-1:0]  inh_afsel
);

  logic [PINS-1:0] pin_frozen;

  assign pin_frozen = locked ? mask : '0;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    assign inh_mode [g*MODE_W +: MODE_W] = {MODE_W{pin_frozen[g]}};
    assign inh_otype[g]                  = pin_frozen[g];
    assign inh_speed[g*SPD_W  +: SPD_W]  = {SPD_W{pin_frozen[g]}};
    assign inh_pull [g*PULL_W +: PULL_W] = {PULL_W{pin_frozen[g]}};
    assign inh_afsel[g*AFS_W  +: AFS_W]  = {AFS_W{pin_frozen[g]}};
  end

  p_quiet_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (inh_mode == '0 && inh_otype == '0 && inh_speed == '0
                 && inh_pull == '0 && inh_afsel == '0));

  p_otype_within_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_otype & ~mask) == '0);

endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cfg_lock_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DW     = 32,
  parameter int MODE_W = 2,
  parameter int SPD_W  = 2,
  parameter int PULL_W = 2,
  parameter int AFS_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [1:0]             acc_size,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [PINS-1:0]        lock_mask,
  output logic                   key_active,
  output logic [PINS*MODE_W-1:0] inh_mode,
  output logic [PINS-1:0]        inh_otype,
  output logic [PINS*SPD_W-1:0]  inh_speed,
  output logic [PINS*PULL_W-1:0] inh_pull,
  output logic [PINS*AFS_W-1:0]  inh_afsel
);

  localparam int KEY_POS = PINS;

  seq_state_t seq_state;
  logic       locked, key_rd, commit_ev, abort_ev;
  logic       unused_hi;

  assign unused_hi = ^{wdata[DW-1:KEY_POS+1], seq_state, commit_ev, abort_ev};

  cfg_lock_fsm #(.PINS(PINS)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .acc_size  (acc_size),
    .wkey      (wdata[KEY_POS]),
    .wmask     (wdata[PINS-1:0]),
    .state     (seq_state),
    .locked    (locked),
    .key_rd    (key_rd),
    .commit_ev (commit_ev),
    .abort_ev  (abort_ev)
  );

  cfg_lock_mask #(.PINS(PINS)) i_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .acc_size (acc_size),
    .wmask    (wdata[PINS-1:0]),
    .locked   (locked),
    .mask     (lock_mask)
  );

  cfg_lock_fanout #(
    .PINS(PINS), .MODE_W(MODE_W), .SPD_W(SPD_W), .PULL_W(PULL_W), .AFS_W(AFS_W)
  ) i_fanout (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask      (lock_mask),
    .locked    (locked),
    .inh_mode  (inh_mode),
    .inh_otype (inh_otype),
    .inh_speed (inh_speed),
    .inh_pull  (inh_pull),
    .inh_afsel (inh_afsel)
  );

  always_comb begin
    rdata                = '0;
    rdata[PINS-1:0]      = lock_mask;
    rdata[KEY_POS]       = key_rd;
  end

  assign key_active = locked;

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:KEY_POS+1] == '0);

  p_key_bit_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
    key_active |-> rdata[KEY_POS]);

endmodule

// File: tb/test_cfg_lock_seq.sv
module test_cfg_lock_seq;

  localparam int PINS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  acc_size = 2'b10;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] lock_mask;
  logic        key_active;
  logic [31:0] inh_mode;
  logic [15:0] inh_otype;
  logic [31:0] inh_speed;
  logic [31:0] inh_pull;
  logic [63:0] inh_afsel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cfg_lock_seq i_cfg_lock_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .acc_size(acc_size), .wdata(wdata), .rdata(rdata),
    .lock_mask(lock_mask), .key_active(key_active),
    .inh_mode(inh_mode), .inh_otype(inh_otype), .inh_speed(inh_speed),
    .inh_pull(inh_pull), .inh_afsel(inh_afsel)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    acc_size = sz; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; acc_size = 2'b10;
  endtask

  task automatic rd(output logic [31:0] v);
    rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] kw(input logic k, input logic [15:0] m);
    return {15'b0, k, m};
  endfunction

  task automatic check_inhibits(input string req, input logic [15:0] m, input logic on);
    logic [31:0] e_mode, e_spd, e_pull;
    logic [15:0] e_ot;
    logic [63:0] e_af;
    for (int p = 0; p < PINS; p++) begin
      e_mode[2*p +: 2] = (on && m[p]) ? 2'b11 : 2'b00;
      e_spd [2*p +: 2] = (on && m[p]) ? 2'b11 : 2'b00;
      e_pull[2*p +: 2] = (on && m[p]) ? 2'b11 : 2'b00;
      e_ot  [p]        = on && m[p];
      e_af  [4*p +: 4] = (on && m[p]) ? 4'hF : 4'h0;
    end
    check({req, " mode"},  {32'b0, inh_mode},  {32'b0, e_mode});
    check({req, " otype"}, {48'b0, inh_otype}, {48'b0, e_ot});
    check({req, " speed"}, {32'b0, inh_speed}, {32'b0, e_spd});
    check({req, " pull"},  {32'b0, inh_pull},  {32'b0, e_pull});
    check({req, " afsel"}, inh_afsel, e_af);
  endtask

  // finish a pattern attempt with a read and confirm the key stayed off
  task automatic expect_no_lock(input string req);
    logic [31:0] v;
    rd(v);
    check({req, " read key"}, {63'b0, v[16]}, 64'd0);
    check({req, " key_active"}, {63'b0, key_active}, 64'd0);
  endtask

  initial begin : main
    logic [31:0] v;
    logic [15:0] masks [6];
    masks[0] = 16'hFFFF; masks[1] = 16'hA5A5; masks[2] = 16'h0000;
    masks[3] = 16'h8001; masks[4] = 16'h7E18; masks[5] = 16'h5555;

    do_reset();
    // R1 reset state
    check("R1 rdata", {32'b0, rdata}, 64'd0);
    check("R1 key", {63'b0, key_active}, 64'd0);
    check_inhibits("R1", 16'hFFFF, 1'b0);

    // R2 write lanes, R11 reserved bits
    wr(2'b10, 32'hFFFE_1234);
    check("R2 word", {48'b0, lock_mask}, 64'h1234);
    check("R11 upper zero", {32'b0, rdata}, 64'h0000_1234);
    wr(2'b01, 32'h0000_ABCD);
    check("R2 half", {48'b0, lock_mask}, 64'hABCD);
    wr(2'b00, 32'h0000_77EF);
    check("R2 byte", {48'b0, lock_mask}, 64'hABEF);
    wr(2'b11, 32'h0000_0000);
    check("R2 reserved size", {48'b0, lock_mask}, 64'hABEF);
    check_inhibits("R10 unlocked", 16'hFFFF, 1'b0);

    // R3 R4 R9 R10 sweep: each single pin plus dense masks
    for (int n = 0; n < PINS + 6; n++) begin
      logic [15:0] m;
      m = (n < PINS) ? (16'h1 << n) : masks[n - PINS];
      do_reset();
      wr(2'b10, kw(1'b1, m));
      wr(2'b10, kw(1'b0, m));
      wr(2'b10, kw(1'b1, m));
      check("R4 key before read", {63'b0, key_active}, 64'd0);
      rd(v);
      check("R4 read returns key", {32'b0, v}, {31'b0, 1'b1, m});
      check("R3 key active", {63'b0, key_active}, 64'd1);
      check_inhibits("R10", m, 1'b1);
      wr(2'b10, kw(1'b0, ~m));
      wr(2'b01, {16'h0, ~m});
      check("R9 mask frozen", {48'b0, lock_mask}, {48'b0, m});
      wr(2'b10, kw(1'b1, ~m)); wr(2'b10, kw(1'b0, ~m));
      wr(2'b10, kw(1'b1, ~m)); rd(v);
      check("R9 relock ignored", {32'b0, rdata}, {31'b0, 1'b1, m});
      check("R9 key sticky", {63'b0, key_active}, 64'd1);
    end
    do_reset();
    check("R9 reset clears", {32'b0, rdata}, 64'd0);

    // R5 mask change
    do_reset();
    wr(2'b10, kw(1'b1, 16'h00F0)); wr(2'b10, kw(1'b0, 16'h00F1));
    wr(2'b10, kw(1'b1, 16'h00F0));
    expect_no_lock("R5 second step");
    wr(2'b10, kw(1'b1, 16'h00F0)); wr(2'b10, kw(1'b0, 16'h00F0));
    wr(2'b10, kw(1'b1, 16'h0F00));
    expect_no_lock("R5 third step");

    // R6 narrow access at each step
    for (int s = 0; s < 3; s++) begin
      for (int z = 0; z < 4; z++) begin
        logic [1:0] sz;
        sz = (z == 2) ? 2'b11 : z[1:0];
        do_reset();
        wr((s == 0) ? sz : 2'b10, kw(1'b1, 16'h3C3C));
        wr((s == 1) ? sz : 2'b10, kw(1'b0, 16'h3C3C));
        wr((s == 2) ? sz : 2'b10, kw(1'b1, 16'h3C3C));
        expect_no_lock("R6 narrow");
      end
    end

    // R7 early read, wrong order
    do_reset();
    wr(2'b10, kw(1'b1, 16'h1111)); rd(v);
    wr(2'b10, kw(1'b0, 16'h1111)); wr(2'b10, kw(1'b1, 16'h1111));
    expect_no_lock("R7 read after first");
    wr(2'b10, kw(1'b1, 16'h1111)); wr(2'b10, kw(1'b0, 16'h1111)); rd(v);
    wr(2'b10, kw(1'b1, 16'h1111));
    expect_no_lock("R7 read after second");
    wr(2'b10, kw(1'b1, 16'h1111)); wr(2'b10, kw(1'b0, 16'h1111));
    wr(2'b10, kw(1'b0, 16'h1111)); wr(2'b10, kw(1'b1, 16'h1111));
    expect_no_lock("R7 double zero");
    wr(2'b10, kw(1'b0, 16'h1111)); wr(2'b10, kw(1'b1, 16'h1111));
    wr(2'b10, kw(1'b0, 16'h1111));
    expect_no_lock("R7 zero first");

    // R8 restarts
    do_reset();
    wr(2'b10, kw(1'b1, 16'h2222)); wr(2'b10, kw(1'b1, 16'h2222));
    wr(2'b10, kw(1'b0, 16'h2222)); wr(2'b10, kw(1'b1, 16'h2222)); rd(v);
    check("R8 repeated first step", {47'b0, key_active, lock_mask}, {47'b0, 1'b1, 16'h2222});
    do_reset();
    wr(2'b10, kw(1'b1, 16'h4444)); wr(2'b10, kw(1'b0, 16'h4444));
    wr(2'b10, kw(1'b1, 16'h0990)); wr(2'b10, kw(1'b0, 16'h0990));
    wr(2'b10, kw(1'b1, 16'h0990)); rd(v);
    check("R8 restart new mask", {47'b0, key_active, lock_mask}, {47'b0, 1'b1, 16'h0990});
    check_inhibits("R8 R10", 16'h0990, 1'b1);
    do_reset();
    wr(2'b10, kw(1'b1, 16'h6006)); wr(2'b10, kw(1'b0, 16'h6006));
    wr(2'b10, kw(1'b1, 16'h6006)); wr(2'b10, kw(1'b1, 16'h6006));
    expect_no_lock("R8 write in armed restarts");

    done = 1'b1;
  end

  initial begin : finish_ctl
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule